// File: doc/BRIEF.md
# Windowed Throughput Monitor for Cluster Power Gating

This block watches a superscalar core's issue and retirement activity and recommends when a spare execution cluster may be switched off or should be switched back on. Every cycle it receives the number of instructions issued and the number committed, up to eight of each. It sums both over a fixed window of cycles, 512 by default. At the end of each window it compares the sums against count thresholds, so no division is needed. A low commit total suggests that the extra cluster is idle. Issue running far ahead of commit suggests wrong-path work. Either result argues for power-down. When the core is already in its reduced mode, a high commit total or commit running ahead of issue argues for power-up.

The surrounding mode controller tells the monitor which mode the core is in through `lowMode`. Each test is only evaluated in the mode it applies to. Each window's verdict in each direction is pushed into a short history. A request is raised only when enough recent windows agree, which keeps one noisy window from causing a mode switch. A request is a one-cycle pulse. The totals of the window just closed are held on the outputs for observation until the next window closes.

Top module: `ipc_window_monitor`

## Requirements
- R1: A window covers exactly WINDOW_LEN (default 512) consecutive cycles, the first one being the first cycle after reset is released. `lastIssue` and `lastCommit` take the window's totals in the cycle after the window's final cycle and hold them until the next window closes.
- R2: Any per-cycle count above MAX_PER_CYCLE (default 8) is counted as MAX_PER_CYCLE.
- R3: With `lowMode` = 0 in a window's final cycle, a window whose commit total is strictly below DOWN_COMMIT_TH (default 1024, i.e. 2.0 per cycle) is a power-down vote. A total of exactly 1024 is not a vote.
- R4: With `lowMode` = 1 in the final cycle, a commit total strictly above UP_COMMIT_TH (default 512, i.e. 1.0 per cycle) is a power-up vote. A total of exactly 512 is not a vote.
- R5: With `lowMode` = 0, a window where issue total minus commit total is strictly greater than DELTA_DOWN_TH (default 512) is a power-down vote.
- R6: With `lowMode` = 1, a window where commit total minus issue total is strictly greater than DELTA_UP_TH (default 256) is a power-up vote.
- R7: No power-down vote is cast while `lowMode` = 1, and no power-up vote is cast while `lowMode` = 0, whatever the totals.
- R8: Each direction keeps a history of its last HIST_LEN (default 3) window verdicts. A request fires when at least VOTE_NEED (default 2) of them are votes, counting the window just closed. Firing empties that direction's history.
- R9: `downReq` and `upReq` are single-cycle pulses that appear only in the cycle after a window's final cycle, and they are never high together.
- R10: Reset clears both requests, both held totals, the partial window and both histories.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lowMode | input | 1 | 1 while the core runs with a cluster switched off |
| issueCnt | input | IN_W (4) | Instructions issued this cycle |
| commitCnt | input | IN_W (4) | Instructions committed this cycle |
| downReq | output | 1 | One-cycle power-down recommendation |
| upReq | output | 1 | One-cycle power-up recommendation |
| lastIssue | output | ACC_W (13) | Issue total of the last completed window |
| lastCommit | output | ACC_W (13) | Commit total of the last completed window |

## Verification
A fault in the accumulators or the clamp shows up one cycle after the window closes, as a wrong `lastIssue` or `lastCommit`. A misaligned cycle counter makes those totals wrong in the same cycle, and a request then lands off the boundary. A corrupted vote history stays hidden until a later window: a missing or extra pulse shows up at the second boundary after the fault, or later when the history is deeper. The bench therefore runs windows back to back, including a reset in the middle of a window, and compares every boundary's pulses and totals against a model of the history it keeps itself.

// File: rtl/ipcmon_pkg.sv
package ipcmon_pkg;

  // Strobes from the window sequencer to the accumulating datapath.
  typedef struct packed {
    logic accClear;   // restart accumulation next cycle
    logic capture;    // latch this window's totals
  } winStrobe_t;

endpackage

// File: rtl/window_datapath.sv
module window_datapath
  import ipcmon_pkg::*;
#(
  parameter int MAX_PER_CYCLE  = 8,
  parameter int IN_W           = 4,
  parameter int ACC_W          = 13,
  parameter int DOWN_COMMIT_TH = 1024,
  parameter int UP_COMMIT_TH   = 512,
  parameter int DELTA_DOWN_TH  = 512,
  parameter int DELTA_UP_TH    = 256
) (
  input  logic             clk,
  input  logic             rstN,
  input  winStrobe_t       strobe,
  input  logic [IN_W-1:0]  issueCnt,
  input  logic [IN_W-1:0]  commitCnt,
  output logic             downHit,
  output logic             upHit,
  output logic [ACC_W-1:0] lastIssue,
  output logic [ACC_W-1:0] lastCommit
);

  localparam int DW = ACC_W + 1;
  localparam logic [IN_W-1:0]      MAXV   = IN_W'(MAX_PER_CYCLE);
  localparam logic [ACC_W-1:0]     DOWNTH = ACC_W'(DOWN_COMMIT_TH);
  localparam logic [ACC_W-1:0]     UPTH   = ACC_W'(UP_COMMIT_TH);
  localparam logic signed [DW-1:0] DDN    = DW'(DELTA_DOWN_TH);
  localparam logic signed [DW-1:0] DUPN   = -$signed(DW'(DELTA_UP_TH));

  logic [ACC_W-1:0] issueAcc, commitAcc;
  logic [ACC_W-1:0] issueStep, commitStep;
  logic [ACC_W-1:0] issueSum, commitSum;
  logic signed [DW-1:0] deltaSum;

  // Saturate each per-cycle count before it enters the window total.
  assign issueStep  = ACC_W'((issueCnt  > MAXV) ? MAXV : issueCnt);
  assign commitStep = ACC_W'((commitCnt > MAXV) ? MAXV : commitCnt);

  // Totals including the current cycle; only meaningful at capture.
  assign issueSum  = issueAcc + issueStep;
  assign commitSum = commitAcc + commitStep;
  assign deltaSum  = $signed({1'b0, issueSum}) - $signed({1'b0, commitSum});

  assign downHit = (commitSum < DOWNTH) || (deltaSum > DDN);
  assign upHit   = (commitSum > UPTH)   || (deltaSum < DUPN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      issueAcc   <= '0;
      commitAcc  <= '0;
      lastIssue  <= '0;
      lastCommit <= '0;
    end else begin
      if (strobe.accClear) begin
        issueAcc  <= '0;
        commitAcc <= '0;
      end else begin
        issueAcc  <= issueSum;
        commitAcc <= commitSum;
      end
      if (strobe.capture) begin
        lastIssue  <= issueSum;
        lastCommit <= commitSum;
      end
    end
  end

endmodule

// File: rtl/window_ctrl.sv
module window_ctrl
  import ipcmon_pkg::*;
#(
  parameter int WINDOW_LEN = 512,
  parameter int HIST_LEN   = 3,
  parameter int VOTE_NEED  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       lowMode,
  input  logic       downHit,
  input  logic       upHit,
  output winStrobe_t strobe,
  output logic       downReq,
  output logic       upReq
);

  localparam int CYC_W = (WINDOW_LEN > 1) ? $clog2(WINDOW_LEN) : 1;
  localparam logic [CYC_W-1:0] LAST_CYC = CYC_W'(WINDOW_LEN - 1);

  logic [CYC_W-1:0] cycCnt;
  logic             winLast;
  logic [1:0]       vote;   // [0] power-down, [1] power-up
  logic [1:0]       fire;

  assign winLast         = (cycCnt == LAST_CYC);
  assign strobe.accClear = winLast;
  assign strobe.capture  = winLast;

  assign vote[0] = winLast & ~lowMode & downHit;
  assign vote[1] = winLast &  lowMode & upHit;

  always_ff @(posedge clk) begin
    if (!rstN)        cycCnt <= '0;
    else if (winLast) cycCnt <= '0;
    else              cycCnt <= cycCnt + 1'b1;
  end

  function automatic int popCount(input logic [HIST_LEN-1:0] v);
    int n = 0;
    for (int k = 0; k < HIST_LEN; k++) n += int'(v[k]);
    return n;
  endfunction

  for (genvar d = 0; d < 2; d++) begin : g_dir
    if (HIST_LEN == 1) begin : g_direct
      assign fire[d] = vote[d];
    end else begin : g_hist
      logic [HIST_LEN-1:0] hist, histNext;
      assign histNext = {hist[HIST_LEN-2:0], vote[d]};
      assign fire[d]  = winLast && (popCount(histNext) >= VOTE_NEED);
      always_ff @(posedge clk) begin
        if (!rstN)        hist <= '0;
        else if (winLast) hist <= fire[d] ? '0 : histNext;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      downReq <= 1'b0;
      upReq   <= 1'b0;
    end else begin
      downReq <= fire[0];
      upReq   <= fire[1];
    end
  end

endmodule

// File: rtl/ipc_window_monitor.sv
module ipc_window_monitor
  import ipcmon_pkg::*;
#(
  parameter int WINDOW_LEN     = 512,
  parameter int MAX_PER_CYCLE  = 8,
  parameter int IN_W           = 4,
  parameter int DOWN_COMMIT_TH = 2 * WINDOW_LEN,
  parameter int UP_COMMIT_TH   = WINDOW_LEN,
  parameter int DELTA_DOWN_TH  = WINDOW_LEN,
  parameter int DELTA_UP_TH    = WINDOW_LEN / 2,
  parameter int HIST_LEN       = 3,
  parameter int VOTE_NEED      = 2,
  localparam int ACC_W         = $clog2(MAX_PER_CYCLE * WINDOW_LEN + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lowMode,
  input  logic [IN_W-1:0]  issueCnt,
  input  logic [IN_W-1:0]  commitCnt,
  output logic             downReq,
  output logic             upReq,
  output logic [ACC_W-1:0] lastIssue,
  output logic [ACC_W-1:0] lastCommit
);

  winStrobe_t strobe;
  logic       downHit, upHit;

  window_ctrl #(
    .WINDOW_LEN(WINDOW_LEN),
    .HIST_LEN  (HIST_LEN),
    .VOTE_NEED (VOTE_NEED)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .lowMode(lowMode),
    .downHit(downHit),
    .upHit  (upHit),
    .strobe (strobe),
    .downReq(downReq),
    .upReq  (upReq)
  );

  window_datapath #(
    .MAX_PER_CYCLE (MAX_PER_CYCLE),
    .IN_W          (IN_W),
    .ACC_W         (ACC_W),
    .DOWN_COMMIT_TH(DOWN_COMMIT_TH),
    .UP_COMMIT_TH  (UP_COMMIT_TH),
    .DELTA_DOWN_TH (DELTA_DOWN_TH),
    .DELTA_UP_TH   (DELTA_UP_TH)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .issueCnt  (issueCnt),
    .commitCnt (commitCnt),
    .downHit   (downHit),
    .upHit     (upHit),
    .lastIssue (lastIssue),
    .lastCommit(lastCommit)
  );

endmodule

// File: rtl/ipc_window_monitor_chk.sv
module ipc_window_monitor_chk #(
  parameter int WINDOW_LEN    = 512,
  parameter int MAX_PER_CYCLE = 8,
  parameter int ACC_W         = 13
) (
  input logic             clk,
  input logic             rstN,
  input logic             lowMode,
  input logic             downReq,
  input logic             upReq,
  input logic [ACC_W-1:0] lastIssue,
  input logic [ACC_W-1:0] lastCommit
);

  localparam int CW = (WINDOW_LEN > 1) ? $clog2(WINDOW_LEN) : 1;
  localparam logic [ACC_W-1:0] TOTAL_MAX = ACC_W'(MAX_PER_CYCLE * WINDOW_LEN);

  // Independent window position tracker; 0 marks the cycle after a boundary.
  logic [CW-1:0] chkPos;
  always_ff @(posedge clk) begin
    if (!rstN)                                 chkPos <= '0;
    else if (chkPos == CW'(WINDOW_LEN - 1))    chkPos <= '0;
    else                                       chkPos <= chkPos + 1'b1;
  end

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (downReq || upReq) |=> !(downReq || upReq));

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(downReq && upReq));

  a_r9_boundary_only: assert property (@(posedge clk) disable iff (!rstN)
    (downReq || upReq) |-> (chkPos == '0));

  a_r1_hold: assert property (@(posedge clk) disable iff (!rstN)
    (chkPos != '0) |-> ($stable(lastIssue) && $stable(lastCommit)));

  a_r7_down_full_mode: assert property (@(posedge clk) disable iff (!rstN)
    downReq |-> !$past(lowMode));

  a_r7_up_low_mode: assert property (@(posedge clk) disable iff (!rstN)
    upReq |-> $past(lowMode));

  a_r2_bound: assert property (@(posedge clk) disable iff (!rstN)
    (lastIssue <= TOTAL_MAX) && (lastCommit <= TOTAL_MAX));

endmodule

bind ipc_window_monitor ipc_window_monitor_chk #(
  .WINDOW_LEN   (WINDOW_LEN),
  .MAX_PER_CYCLE(MAX_PER_CYCLE),
  .ACC_W        (ACC_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .lowMode   (lowMode),
  .downReq   (downReq),
  .upReq     (upReq),
  .lastIssue (lastIssue),
  .lastCommit(lastCommit)
);

// File: tb/test_ipc_window_monitor.sv
`timescale 1ns/1ps
module test_ipc_window_monitor;

  localparam int WL      = 512;
  localparam int MAXP    = 8;
  localparam int HL      = 3;
  localparam int VN      = 2;
  localparam int DOWN_TH = 1024;
  localparam int UP_TH   = 512;
  localparam int DD      = 512;
  localparam int DU      = 256;
  localparam int AW      = 13;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          lowMode = 1'b0;
  logic [3:0]    issueCnt = '0;
  logic [3:0]    commitCnt = '0;
  logic          downReq, upReq;
  logic [AW-1:0] lastIssue, lastCommit;

  int  checkCnt = 0;
  int  failCnt  = 0;
  bit  done     = 0;
  int  mHist[2];

  ipc_window_monitor #(
    .WINDOW_LEN(WL), .MAX_PER_CYCLE(MAXP), .IN_W(4),
    .DOWN_COMMIT_TH(DOWN_TH), .UP_COMMIT_TH(UP_TH),
    .DELTA_DOWN_TH(DD), .DELTA_UP_TH(DU),
    .HIST_LEN(HL), .VOTE_NEED(VN)
  ) i_ipc_window_monitor (
    .clk(clk), .rstN(rstN), .lowMode(lowMode),
    .issueCnt(issueCnt), .commitCnt(commitCnt),
    .downReq(downReq), .upReq(upReq),
    .lastIssue(lastIssue), .lastCommit(lastCommit)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v > MAXP) ? MAXP : v;
  endfunction

  function automatic int ones(input int h);
    int n = 0;
    for (int k = 0; k < HL; k++) n += (h >> k) & 1;
    return n;
  endfunction

  // History model per R8.
  task automatic histStep(input int d, input bit v, output bit f);
    mHist[d] = ((mHist[d] << 1) | int'(v)) & ((1 << HL) - 1);
    f = (ones(mHist[d]) >= VN);
    if (f) mHist[d] = 0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    issueCnt = '0;
    commitCnt = '0;
    repeat (3) @(negedge clk);
    check(downReq == 1'b0, "R10 downReq in reset", int'(downReq), 0);
    check(upReq == 1'b0, "R10 upReq in reset", int'(upReq), 0);
    check(lastIssue == '0, "R10 lastIssue in reset", int'(lastIssue), 0);
    check(lastCommit == '0, "R10 lastCommit in reset", int'(lastCommit), 0);
    mHist[0] = 0;
    mHist[1] = 0;
    rstN = 1'b1;
  endtask

  task automatic runWindow(input bit mode, input int kind, input string tag,
                           input int maxI = 0, input int maxC = 0);
    int iSum = 0;
    int cSum = 0;
    bit stray = 0;
    int iv, cv;
    bit dv, uv, eDown, eUp;
    lowMode = mode;
    for (int c = 0; c < WL; c++) begin
      case (kind)
        0:       begin iv = 3; cv = 3; end
        1:       begin iv = 1; cv = 1; end
        2:       begin iv = 2; cv = 2; end
        3:       begin iv = 2; cv = (c == 0) ? 1 : 2; end
        4:       begin iv = 6 + int'($urandom_range(0, 2)); cv = 3; end
        5:       begin iv = 9 + int'($urandom_range(0, 6)); cv = 9 + int'($urandom_range(0, 6)); end
        6:       begin iv = 0; cv = 1; end
        7:       begin iv = c % 2; cv = 1; end
        8:       begin iv = 4; cv = 1; end
        9:       begin iv = 3; cv = 2; end
        default: begin iv = int'($urandom_range(0, maxI)); cv = int'($urandom_range(0, maxC)); end
      endcase
      issueCnt  = 4'(iv);
      commitCnt = 4'(cv);
      iSum += sat(iv);
      cSum += sat(cv);
      @(negedge clk);
      if (c < WL - 1 && (downReq || upReq)) stray = 1;
    end
    dv = !mode && ((cSum < DOWN_TH) || ((iSum - cSum) > DD));
    uv =  mode && ((cSum > UP_TH)   || ((cSum - iSum) > DU));
    histStep(0, dv, eDown);
    histStep(1, uv, eUp);
    check(int'(lastIssue) == iSum, {tag, " R1 R2 issue total"}, int'(lastIssue), iSum);
    check(int'(lastCommit) == cSum, {tag, " R1 R2 commit total"}, int'(lastCommit), cSum);
    check(downReq == eDown, {tag, " downReq"}, int'(downReq), int'(eDown));
    check(upReq == eUp, {tag, " upReq"}, int'(upReq), int'(eUp));
    check(stray == 1'b0, {tag, " R9 pulse off boundary"}, int'(stray), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog R1: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    mHist[0] = 0;
    mHist[1] = 0;
    @(negedge clk);
    doReset();

    runWindow(0, 0, "R3 high commit");
    runWindow(0, 1, "R3 R8 first vote");
    runWindow(0, 1, "R3 R8 second vote");
    runWindow(0, 2, "R3 exact 1024");
    runWindow(0, 3, "R3 commit 1023");
    runWindow(0, 4, "R5 R8 misspeculation");
    runWindow(0, 9, "R5 delta exactly 512");
    runWindow(1, 1, "R4 commit exactly 512");
    runWindow(1, 2, "R4 R8 vote");
    runWindow(1, 5, "R2 R4 saturated inputs");
    runWindow(1, 6, "R6 commit outpaces issue");
    runWindow(1, 7, "R6 delta exactly 256");
    runWindow(1, 8, "R7 down gated");
    runWindow(0, 0, "R7 up gated");
    runWindow(0, 1, "R8 vote before reset");

    // Reset in the middle of a window must discard partial sums and history.
    lowMode = 1'b0;
    for (int c = 0; c < 200; c++) begin
      issueCnt = 4'd7;
      commitCnt = 4'd0;
      @(negedge clk);
    end
    doReset();
    runWindow(0, 1, "R10 history cleared");
    runWindow(0, 1, "R10 R8 fires after reset");

    for (int r = 0; r < 10; r++) begin
      runWindow(bit'($urandom_range(0, 1)), 10, "R8 random",
                int'($urandom_range(0, 12)), int'($urandom_range(0, 12)));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

endmodule